// File: doc/BRIEF.md
# Receive Packet Tagger with Error and BAR Capture

This block sits on the application side of a streaming receive path from a PCI Express transaction layer. Each beat carries a valid strobe, start and end-of-packet marks, an uncorrectable-error flag, an 8-bit decoded BAR vector and the format/type byte of the first header dword. Bits 31:24 of the beat's data lane carry that byte. Payload bits are not needed and do not enter the block.

For every transaction layer packet the block emits one descriptor. The descriptor holds the BAR hit, a packet class, the length in beats and a status: good, corrupted or framing error. A parameter selects a 64-bit or a 128-bit datapath, and that choice sets the beat on which the BAR vector is meaningful. The block does not store payload.

A packet that is cut short by an uncorrectable error and still closed by an end-of-packet beat is reported as corrupted with the length it actually had. A packet that is never closed is reported with a framing status when the next packet starts. If such a packet also carried an error, a sticky reset request is raised.

Top module: `rxtag_top`

## Requirements
- R1: While reset is applied, and on the first cycles after release, `pkt_valid` and `reset_req` are low.
- R2: The class comes from the first beat's byte (bits 7:5 are the format, bit 6 means data attached, bits 4:0 are the type). The encoding is:
  - type 00000 or 00001 without data gives 0 (memory read); with data it gives 1 (memory write).
  - type 00010 without data gives 2 (I/O read); with data it gives 3 (I/O write).
  - type 01010 or 01011 gives 4 (completion).
  - type 10xxx gives 5 (message).
  - anything else gives 7. Code 6 is never produced.
- R3: For classes 0 to 3, the BAR hit is the `rx_bar` value on the packet's beat index 1 when DATA_W is 64, and on beat index 0 when DATA_W is 128. A 64-bit packet of one beat reports 0.
- R4: For classes 4, 5 and 7 the BAR hit is 0.
- R5: The length is the number of valid beats from start to end inclusive, saturating at 2^LEN_W-1.
- R6: The status is 1 (corrupted) if `rx_err` was high on any valid beat of the packet, otherwise 0 (good). A packet that ends early on an end-of-packet beat after an error is reported with status 1 and its real length.
- R7: A start-of-packet beat arriving while a packet is open closes the open packet with status 2 (framing), and the new packet begins on that same beat.
- R8: `reset_req` rises, and stays high until reset, when a packet closed by framing had an error. A corrupted packet closed by end-of-packet does not raise it.
- R9: A descriptor appears the cycle after the beat that closes its packet. If a framing close and a single-beat packet fall on the same beat, the framing descriptor comes first and the other follows one cycle later. Order is always kept.
- R10: A valid beat without start-of-packet while no packet is open is ignored, including its end and error marks. It produces no descriptor and no reset request.
- R11: Beats with `rx_valid` low are ignored, whatever their other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Beat valid |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_err | input | 1 | Uncorrectable buffer error on this beat |
| rx_bar | input | 8 | Decoded BAR vector |
| rx_fmt_type | input | 8 | Bits 31:24 of the beat's data lane |
| pkt_valid | output | 1 | Descriptor strobe |
| pkt_bar | output | 8 | BAR hit of the packet |
| pkt_class | output | 3 | Packet class code |
| pkt_beats | output | LEN_W | Packet length in beats |
| pkt_status | output | 2 | 0 good, 1 corrupted, 2 framing |
| reset_req | output | 1 | Sticky reset request |

## Verification
The framing close of an open packet and the completion of a one-beat packet can both happen on the same beat. This is the only case that produces two descriptors in one cycle. It is provoked directly, with a truncated packet followed at once by a beat marked both start and end, and it also arises in random traffic, where unclosed packets and short packets are mixed. The bench judges it by the order of the descriptors and by the exact cycle of each one: it expects the second descriptor exactly one cycle late and every later descriptor shifted to match. The same stimulus drives a 64-bit and a 128-bit instance, so that each also checks its own BAR beat.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;

  typedef enum logic [2:0] {
    CLS_MRD   = 3'd0,
    CLS_MWR   = 3'd1,
    CLS_IORD  = 3'd2,
    CLS_IOWR  = 3'd3,
    CLS_CPL   = 3'd4,
    CLS_MSG   = 3'd5,
    CLS_OTHER = 3'd7
  } pkt_cls_e;

  typedef enum logic [1:0] {
    ST_GOOD    = 2'd0,
    ST_CORRUPT = 2'd1,
    ST_FRAMING = 2'd2
  } pkt_st_e;

  typedef struct packed {
    logic [7:0] bar;
    pkt_cls_e   cls;
    pkt_st_e    st;
  } pkt_hdr_t;

  // Only memory and I/O requests carry a meaningful BAR vector.
  function automatic logic cls_uses_bar(input pkt_cls_e c);
    return (c == CLS_MRD) || (c == CLS_MWR) || (c == CLS_IORD) || (c == CLS_IOWR);
  endfunction

endpackage

// File: rtl/rxtag_rst_sync.sv
module rxtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rxtag_classify.sv
module rxtag_classify
  import rxtag_pkg::*;
(
  input  logic [7:0] fmt_type,
  output pkt_cls_e   cls
);
  logic       has_data;
  logic [4:0] typ;

  assign has_data = fmt_type[6];
  assign typ      = fmt_type[4:0];

  always_comb begin
    if (typ[4:1] == 4'b0000)       cls = has_data ? CLS_MWR  : CLS_MRD;
    else if (typ == 5'b00010)      cls = has_data ? CLS_IOWR : CLS_IORD;
    else if (typ[4:1] == 4'b0101)  cls = CLS_CPL;
    else if (typ[4:3] == 2'b10)    cls = CLS_MSG;
    else                           cls = CLS_OTHER;
  end
endmodule

// File: rtl/rxtag_track.sv
module rxtag_track
  import rxtag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_err,
  input  logic [7:0]       in_bar,
  input  pkt_cls_e         in_cls,
  output logic             f_vld,
  output pkt_hdr_t         f_hdr,
  output logic [LEN_W-1:0] f_beats,
  output logic             e_vld,
  output pkt_hdr_t         e_hdr,
  output logic [LEN_W-1:0] e_beats,
  output logic             rr_set
);
  localparam int               BAR_BEAT = (DATA_W >= 128) ? 0 : 1;
  localparam logic [LEN_W-1:0] CNT_MAX  = '1;

  logic             open_q, open_d;
  logic             err_q, err_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [7:0]       bar_q, bar_d;
  pkt_cls_e         cls_q, cls_d;

  logic             start, cont, beat_en, take_bar;
  logic [LEN_W-1:0] cnt_inc, cur_cnt;
  logic             cur_err;
  logic [7:0]       cur_bar;
  pkt_cls_e         cur_cls;

  assign start   = in_valid & in_sop;
  assign cont    = in_valid & ~in_sop & open_q;
  assign beat_en = start | cont;

  generate
    if (BAR_BEAT == 0) begin : g_bar_first
      assign take_bar = start;
    end else begin : g_bar_later
      assign take_bar = cont && (cnt_q == LEN_W'(BAR_BEAT));
    end
  endgenerate

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + LEN_W'(1);
    cur_cnt = start ? LEN_W'(1) : cnt_inc;
    cur_err = start ? in_err : (err_q | in_err);
    cur_cls = start ? in_cls : cls_q;
    if (take_bar)   cur_bar = in_bar;
    else if (start) cur_bar = '0;
    else            cur_bar = bar_q;
  end

  // Close of an unterminated packet by a new start.
  always_comb begin
    f_vld       = start & open_q;
    f_hdr.bar   = cls_uses_bar(cls_q) ? bar_q : 8'd0;
    f_hdr.cls   = cls_q;
    f_hdr.st    = ST_FRAMING;
    f_beats     = cnt_q;
    rr_set      = f_vld & err_q;
  end

  // Regular close on the end-of-packet beat.
  always_comb begin
    e_vld       = beat_en & in_eop;
    e_hdr.bar   = cls_uses_bar(cur_cls) ? cur_bar : 8'd0;
    e_hdr.cls   = cur_cls;
    e_hdr.st    = cur_err ? ST_CORRUPT : ST_GOOD;
    e_beats     = cur_cnt;
  end

  always_comb begin
    open_d = open_q;
    err_d  = err_q;
    cnt_d  = cnt_q;
    bar_d  = bar_q;
    cls_d  = cls_q;
    if (beat_en) begin
      open_d = ~in_eop;
      err_d  = cur_err;
      cnt_d  = cur_cnt;
      bar_d  = cur_bar;
      cls_d  = cur_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      bar_q  <= '0;
      cls_q  <= CLS_OTHER;
    end else if (beat_en) begin
      open_q <= open_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      bar_q  <= bar_d;
      cls_q  <= cls_d;
    end
  end
endmodule

// File: rtl/rxtag_outq.sv
module rxtag_outq
  import rxtag_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             f_vld,
  input  pkt_hdr_t         f_hdr,
  input  logic [LEN_W-1:0] f_beats,
  input  logic             e_vld,
  input  pkt_hdr_t         e_hdr,
  input  logic [LEN_W-1:0] e_beats,
  output logic             o_vld,
  output pkt_hdr_t         o_hdr,
  output logic [LEN_W-1:0] o_beats,
  output logic             pend_vld,
  output logic             drop
);
  logic             pv_q, pv_d;
  pkt_hdr_t         ph_q, ph_d;
  logic [LEN_W-1:0] pb_q, pb_d;
  logic             ov_d;
  pkt_hdr_t         oh_d;
  logic [LEN_W-1:0] ob_d;
  pkt_hdr_t         new_h;
  logic [LEN_W-1:0] new_b;

  // Oldest first: pending slot, then framing close, then end close.
  always_comb begin
    new_h = f_vld ? f_hdr   : e_hdr;
    new_b = f_vld ? f_beats : e_beats;
    drop  = 1'b0;
    if (pv_q) begin
      ov_d = 1'b1;
      oh_d = ph_q;
      ob_d = pb_q;
      pv_d = f_vld | e_vld;
      ph_d = new_h;
      pb_d = new_b;
      drop = f_vld & e_vld;
    end else begin
      ov_d = f_vld | e_vld;
      oh_d = new_h;
      ob_d = new_b;
      pv_d = f_vld & e_vld;
      ph_d = e_hdr;
      pb_d = e_beats;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      o_vld   <= 1'b0;
      o_hdr   <= '0;
      o_beats <= '0;
      pv_q    <= 1'b0;
      ph_q    <= '0;
      pb_q    <= '0;
    end else begin
      o_vld   <= ov_d;
      if (ov_d) begin
        o_hdr   <= oh_d;
        o_beats <= ob_d;
      end
      pv_q    <= pv_d;
      if (pv_d) begin
        ph_q    <= ph_d;
        pb_q    <= pb_d;
      end
    end
  end

  assign pend_vld = pv_q;
endmodule

// File: rtl/rxtag_top.sv
module rxtag_top
  import rxtag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic             rx_err,
  input  logic [7:0]       rx_bar,
  input  logic [7:0]       rx_fmt_type,
  output logic             pkt_valid,
  output logic [7:0]       pkt_bar,
  output logic [2:0]       pkt_class,
  output logic [LEN_W-1:0] pkt_beats,
  output logic [1:0]       pkt_status,
  output logic             reset_req
);
  logic             rst_sn;
  pkt_cls_e         beat_cls;
  logic             f_vld, e_vld, rr_set;
  pkt_hdr_t         f_hdr, e_hdr, o_hdr;
  logic [LEN_W-1:0] f_beats, e_beats;
  logic             pend_vld, drop;
  logic             rr_q, rr_d;

  rxtag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  rxtag_classify u_cls (
    .fmt_type(rx_fmt_type), .cls(beat_cls)
  );

  rxtag_track #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst_sn(rst_sn),
    .in_valid(rx_valid), .in_sop(rx_sop), .in_eop(rx_eop), .in_err(rx_err),
    .in_bar(rx_bar), .in_cls(beat_cls),
    .f_vld(f_vld), .f_hdr(f_hdr), .f_beats(f_beats),
    .e_vld(e_vld), .e_hdr(e_hdr), .e_beats(e_beats),
    .rr_set(rr_set)
  );

  rxtag_outq #(.LEN_W(LEN_W)) u_outq (
    .clk(clk), .rst_sn(rst_sn),
    .f_vld(f_vld), .f_hdr(f_hdr), .f_beats(f_beats),
    .e_vld(e_vld), .e_hdr(e_hdr), .e_beats(e_beats),
    .o_vld(pkt_valid), .o_hdr(o_hdr), .o_beats(pkt_beats),
    .pend_vld(pend_vld), .drop(drop)
  );

  always_comb rr_d = rr_q | rr_set;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rr_q <= 1'b0;
    else         rr_q <= rr_d;
  end

  assign reset_req  = rr_q;
  assign pkt_bar    = o_hdr.bar;
  assign pkt_class  = o_hdr.cls;
  assign pkt_status = o_hdr.st;
endmodule

// File: rtl/rxtag_chk.sv
module rxtag_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             rx_valid,
  input logic             rx_sop,
  input logic             pkt_valid,
  input logic [7:0]       pkt_bar,
  input logic [2:0]       pkt_class,
  input logic [LEN_W-1:0] pkt_beats,
  input logic [1:0]       pkt_status,
  input logic             reset_req,
  input logic             pend_vld,
  input logic             drop
);
  AST_CLASS_CODE: assert property (@(posedge clk) disable iff (!rst_sn)
    pkt_valid |-> pkt_class != 3'd6); // R2
  AST_NONBAR_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (pkt_valid && pkt_class >= 3'd4) |-> pkt_bar == 8'd0); // R4
  AST_BEATS_NONZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    pkt_valid |-> pkt_beats != '0); // R5
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_sn)
    pkt_valid |-> pkt_status != 2'd3); // R6
  AST_RESET_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    reset_req |=> reset_req); // R8
  AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(reset_req) |-> $past(rx_valid && rx_sop)); // R8
  AST_NO_DESC_LOSS: assert property (@(posedge clk) disable iff (!rst_sn)
    pkt_valid |-> !drop); // R9
  AST_NO_DESC_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    !pkt_valid |-> !drop); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rx_valid && !pend_vld) |=> !pkt_valid); // R11
endmodule

bind rxtag_top rxtag_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .rx_valid(rx_valid), .rx_sop(rx_sop),
  .pkt_valid(pkt_valid), .pkt_bar(pkt_bar), .pkt_class(pkt_class),
  .pkt_beats(pkt_beats), .pkt_status(pkt_status), .reset_req(reset_req),
  .pend_vld(pend_vld), .drop(drop)
);

// File: tb/tb_rxtag_top.sv
module tb_rxtag_top;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic rx_valid, rx_sop, rx_eop, rx_err;
  logic [7:0] rx_bar, rx_ft;

  logic          a_vld, b_vld, a_rr, b_rr;
  logic [7:0]    a_bar, b_bar;
  logic [2:0]    a_cls, b_cls;
  logic [LW-1:0] a_len, b_len;
  logic [1:0]    a_st, b_st;

  rxtag_top #(.DATA_W(64), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err), .rx_bar(rx_bar), .rx_fmt_type(rx_ft),
    .pkt_valid(a_vld), .pkt_bar(a_bar), .pkt_class(a_cls), .pkt_beats(a_len),
    .pkt_status(a_st), .reset_req(a_rr));

  rxtag_top #(.DATA_W(128), .LEN_W(LW)) dut128 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err), .rx_bar(rx_bar), .rx_fmt_type(rx_ft),
    .pkt_valid(b_vld), .pkt_bar(b_bar), .pkt_class(b_cls), .pkt_beats(b_len),
    .pkt_status(b_st), .reset_req(b_rr));

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int e_cls [0:1023];
  int e_len [0:1023];
  int e_st  [0:1023];
  int e_cyc [0:1023];
  int e_b64 [0:1023];
  int e_b128[0:1023];
  int wr = 0, rd64 = 0, rd128 = 0, last_out = -10;
  bit exp_rr = 0, mon_on = 0;
  bit p_open = 0, p_err = 0;
  int p_cls, p_len, p_b64, p_b128;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit uses_bar(input int c);
    return c <= 3;
  endfunction

  // Header byte for a class code, as the classification rule defines it.
  function automatic logic [7:0] ft_for(input int c);
    logic [2:0] f;
    logic [4:0] t;
    logic [31:0] r;
    r = $urandom;
    case (c)
      0: begin f = {2'b00, r[0]}; t = {4'b0000, r[1]}; end
      1: begin f = {2'b01, r[0]}; t = 5'b00000; end
      2: begin f = 3'b000; t = 5'b00010; end
      3: begin f = 3'b010; t = 5'b00010; end
      4: begin f = {1'b0, r[0], 1'b0}; t = {4'b0101, r[1]}; end
      5: begin f = {1'b0, r[0], 1'b1}; t = {2'b10, r[4:2]}; end
      default: begin f = 3'b000; t = r[0] ? 5'b00100 : 5'b11011; end
    endcase
    return {f, t};
  endfunction

  task automatic push(input int c, input int len, input int st,
                      input int b64, input int b128, input int close_cyc);
    int oc;
    oc = close_cyc + 1;
    if (oc <= last_out) oc = last_out + 1;
    last_out = oc;
    e_cls[wr] = c; e_len[wr] = len; e_st[wr] = st;
    e_b64[wr] = b64; e_b128[wr] = b128; e_cyc[wr] = oc;
    wr++;
  endtask

  task automatic beat(input bit v, input bit s, input bit e, input bit er,
                      input logic [7:0] b, input logic [7:0] ft);
    rx_valid = v; rx_sop = s; rx_eop = e; rx_err = er; rx_bar = b; rx_ft = ft;
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) beat(0, 0, 0, 0, 8'd0, 8'd0);
  endtask

  // Invalid beat with random marks: must be ignored (R11).
  task automatic gap();
    if ($urandom % 4 == 0)
      beat(0, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
  endtask

  task automatic send(input int c, input int n, input int eb,
                      input bit close, input bit gaps);
    logic [7:0] b0, b1, bb;
    int len, x64, x128;
    b0 = 8'($urandom); b1 = 8'($urandom);
    len  = (n > 255) ? 255 : n;
    x64  = (uses_bar(c) && n >= 2) ? int'(b1) : 0;
    x128 = uses_bar(c) ? int'(b0) : 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0 && p_open) begin
        push(p_cls, p_len, 2, p_b64, p_b128, cyc);
        if (p_err) exp_rr = 1;
        p_open = 0;
      end
      if (i == n - 1 && close) push(c, len, (eb >= 0) ? 1 : 0, x64, x128, cyc);
      bb = (i == 0) ? b0 : ((i == 1) ? b1 : 8'($urandom));
      beat(1, i == 0, close && (i == n - 1), i == eb, bb,
           (i == 0) ? ft_for(c) : 8'($urandom));
      if (gaps && i != n - 1) gap();
    end
    if (!close) begin
      p_open = 1; p_cls = c; p_len = len; p_b64 = x64; p_b128 = x128; p_err = (eb >= 0);
    end
  endtask

  task automatic cmp(input bit wide, input int idx, input int bar, input int c,
                     input int len, input int st);
    int eb;
    if (idx >= wr) begin
      chk(0, "R10", "unexpected descriptor", idx, wr);
    end else begin
      eb = wide ? e_b128[idx] : e_b64[idx];
      chk(c == e_cls[idx], "R2", "class", c, e_cls[idx]);
      chk(bar == eb, uses_bar(e_cls[idx]) ? "R3" : "R4", "bar", bar, eb);
      chk(len == e_len[idx], "R5", "beats", len, e_len[idx]);
      chk(st == e_st[idx], (e_st[idx] == 2) ? "R7" : "R6", "status", st, e_st[idx]);
      chk(cyc == e_cyc[idx], "R9", "output cycle", cyc, e_cyc[idx]);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (a_vld) begin cmp(0, rd64, a_bar, a_cls, a_len, a_st); rd64++; end
      if (b_vld) begin cmp(1, rd128, b_bar, b_cls, b_len, b_st); rd128++; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", rd64, wr);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m0, m1;
    int before64, before128;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_err = 0; rx_bar = 0; rx_ft = 0;
    repeat (3) @(negedge clk);
    chk(!a_vld && !b_vld, "R1", "valid in reset", a_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!a_vld && !b_vld, "R1", "valid after reset", b_vld, 0);
    chk(!a_rr && !b_rr, "R1", "reset_req after reset", a_rr, 0);
    mon_on = 1;

    send(1, 4, -1, 1, 0);          // good memory write, R3 beat choice
    send(4, 3, -1, 1, 0);          // completion, R4 bar zero
    send(0, 1, -1, 1, 0);          // one-beat read, 64-bit bar 0 (R3)
    send(3, 3, 1, 1, 0);           // early end after error (R6)
    send(5, 2, 1, 1, 0);           // error on last beat (R6)
    idle(3);
    chk(!a_rr && !b_rr, "R8", "no request after closed corrupt packet", a_rr, 0);

    // R11: invalid beat inside a packet with marks set is ignored.
    m0 = 8'($urandom); m1 = 8'($urandom);
    beat(1, 1, 0, 0, m0, ft_for(1));
    beat(0, 1, 1, 1, 8'($urandom), 8'($urandom));
    push(1, 2, 0, int'(m1), int'(m0), cyc);
    beat(1, 0, 1, 0, m1, 8'($urandom));
    idle(3);

    // R10: stray beats without an open packet.
    before64 = rd64; before128 = rd128;
    beat(1, 0, 1, 1, 8'($urandom), 8'($urandom));
    beat(1, 0, 0, 1, 8'($urandom), 8'($urandom));
    idle(3);
    chk(rd64 == before64 && rd128 == before128, "R10", "stray beats produced output",
        rd64 - before64 + rd128 - before128, 0);
    chk(!a_rr && !b_rr, "R10", "stray error raised reset_req", a_rr, 0);

    // R7 and R9: truncated packet, then single-beat packet on the same beat.
    send(0, 3, -1, 0, 0);
    send(2, 1, -1, 1, 0);
    send(1, 2, -1, 1, 0);
    idle(3);
    send(4, 1, -1, 0, 0);          // truncated single beat
    send(5, 1, -1, 1, 0);
    idle(3);

    send(1, 300, -1, 1, 0);        // R5 saturation
    idle(2);

    for (int k = 0; k < 250; k++) begin
      int c, n, eb;
      bit cl;
      c  = $urandom % 7; if (c == 6) c = 7;
      n  = 1 + $urandom % 6;
      eb = ($urandom % 8 == 0) ? int'($urandom % n) : -1;
      cl = (eb >= 0) ? 1'b1 : ($urandom % 8 != 0);
      send(c, n, eb, cl, 1);
      if ($urandom % 3 == 0) idle(1);
    end
    idle(3);
    chk(!a_rr && !b_rr, "R8", "request without framing error", a_rr, 0);

    // R8: truncated packet with error, closed by framing.
    send(3, 2, 0, 0, 0);
    send(1, 3, -1, 1, 0);
    idle(5);
    chk(a_rr == exp_rr && b_rr == exp_rr, "R8", "reset_req after errored framing",
        a_rr, exp_rr);
    chk(rd64 == wr, "R9", "64-bit descriptor count", rd64, wr);
    chk(rd128 == wr, "R9", "128-bit descriptor count", rd128, wr);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule